// File: doc/BRIEF.md
# Two-Slot Integer/FP Issue Pairing Check

This block decides, every cycle, which of the two instructions in a 64-bit fetch packet may leave the decode stage of a two-wide in-order front end. The left half of the packet always carries the integer-slot instruction. The right half always carries the FP-slot instruction. The block receives the decoded register specifiers of both slots, a valid flag and a load flag for each slot, and a stall from the stage below. It returns one grant per slot and a hold request that keeps the fetch stage presenting the same packet.

Issue is in order. The right slot never overtakes a left slot that is still waiting. The two slots issue in the same cycle only when they share no register. A load creates a one-cycle shadow on its destination. That shadow blocks its partner in the same packet, and it also blocks either slot of the packet that follows. If a slot is refused, the packet stays in place and only the slots still outstanding are offered again. A slot that has already issued is never granted a second time.

Top module: `dual_issue_pairing`

## Requirements
- R1: Each register specifier is 7 bits wide. Bit 6 is a valid flag, bit 5 selects the FP register file (1) or the integer register file (0), and bits 4:0 give the register index. Two specifiers name the same register only when both are valid and bits 5:0 are equal. The same index in different files is not a match.
- R2: `grantLeft` is high when all of these hold: the left slot is valid, it has not already issued from the current packet, `stallIn` is low, and neither left source matches a load-shadow entry.
- R3: `grantRight` may be high only when one of these holds: the left slot issues in the same cycle, the left slot already issued earlier from the same packet, or the left slot is not valid. The right slot must also be valid, and neither of its sources may match a load-shadow entry.
- R4: In a cycle where the left slot issues, the right slot does not issue if any of its three specifiers (destination, source A, source B) names the same register as any of the left slot's three specifiers.
- R5: A load in the left slot paired with a right instruction that reads the load's destination issues only the left slot. The right slot stays pending, is blocked again by the shadow in the next cycle, and issues in the cycle after that.
- R6: When a load issues from either slot, its destination becomes a shadow entry. The entry lasts for the next cycle in which `stallIn` is low. In that cycle, any slot with a source that matches the entry does not issue. After that cycle the entry has no effect.
- R7: `fetchHold` is low exactly when `stallIn` is low and every valid slot of the current packet has either issued earlier or issues in this cycle. A packet with no valid slot gives `fetchHold` low.
- R8: A left slot that issued earlier is not granted again while its packet is held. Once `fetchHold` is low, the next packet starts with neither slot marked as issued.
- R9: While `stallIn` is high, neither grant is given, `fetchHold` is high, and the record of issued slots and the shadow entries keep their values.
- R10: After reset, no slot is marked as issued and the shadow is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| stallIn | input | 1 | Stall from the stage below |
| leftValid | input | 1 | Integer-slot instruction present |
| leftIsLoad | input | 1 | Integer-slot instruction is a load |
| leftDst | input | 7 | Integer-slot destination specifier |
| leftSrcA | input | 7 | Integer-slot first source specifier |
| leftSrcB | input | 7 | Integer-slot second source specifier |
| rightValid | input | 1 | FP-slot instruction present |
| rightIsLoad | input | 1 | FP-slot instruction is a load |
| rightDst | input | 7 | FP-slot destination specifier |
| rightSrcA | input | 7 | FP-slot first source specifier |
| rightSrcB | input | 7 | FP-slot second source specifier |
| grantLeft | output | 1 | Integer slot issues this cycle |
| grantRight | output | 1 | FP slot issues this cycle |
| fetchHold | output | 1 | Keep presenting the current packet |

## Verification
Both grants and `fetchHold` are combinational functions of the packet, the stall and the stored state, so they are due in the same cycle the packet is presented. The bench drives inputs on the falling edge and samples 2 ns later. The shadow entries and the issued-slot mark change at the rising edge. Their effect therefore first appears in the sample of the following cycle, and the bench model updates its copies of that state at the same edge, using only values that are legal at that point. Directed sequences cover same-packet load use, next-packet load use, a stall that lands inside the shadow window, and matches across the two register files. A seeded random run with a small register index space then produces frequent conflicts.

// File: rtl/dual_issue_pkg.sv
package dual_issue_pkg;

  localparam int IDX_W     = 5;
  localparam int SPEC_W    = IDX_W + 2;
  localparam int NUM_SLOTS = 2;
  localparam int SPECS_PER_SLOT = 3;
  localparam int SRCS_PER_SLOT  = 2;

  typedef struct packed {
    logic             vld;
    logic             fp;
    logic [IDX_W-1:0] idx;
  } regSpec_t;

  typedef struct packed {
    logic recLeft;
    logic recRight;
    logic freeze;
  } dpStrobe_t;

  function automatic logic specMatch(regSpec_t a, regSpec_t b);
    return a.vld && b.vld && (a.fp == b.fp) && (a.idx == b.idx);
  endfunction

endpackage

// File: rtl/pair_hazard_dp.sv
module pair_hazard_dp
  import dual_issue_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  dpStrobe_t strobe,
  input  regSpec_t  leftDst,
  input  regSpec_t  leftSrcA,
  input  regSpec_t  leftSrcB,
  input  regSpec_t  rightDst,
  input  regSpec_t  rightSrcA,
  input  regSpec_t  rightSrcB,
  output logic      leftShadowHit,
  output logic      rightShadowHit,
  output logic      pairConflict
);

  localparam int HITS_PER_SLOT = SRCS_PER_SLOT * NUM_SLOTS;
  localparam int PAIR_CMPS     = SPECS_PER_SLOT * SPECS_PER_SLOT;

  regSpec_t slotSpec [NUM_SLOTS][SPECS_PER_SLOT];
  regSpec_t shadowQ  [NUM_SLOTS];
  regSpec_t shadowD  [NUM_SLOTS];
  logic [NUM_SLOTS-1:0][HITS_PER_SLOT-1:0] shHit;
  logic [PAIR_CMPS-1:0] cmpBits;

  // index 0 is destination, 1 and 2 are sources
  assign slotSpec[0][0] = leftDst;
  assign slotSpec[0][1] = leftSrcA;
  assign slotSpec[0][2] = leftSrcB;
  assign slotSpec[1][0] = rightDst;
  assign slotSpec[1][1] = rightSrcA;
  assign slotSpec[1][2] = rightSrcB;

  assign shadowD[0] = strobe.recLeft  ? leftDst  : '0;
  assign shadowD[1] = strobe.recRight ? rightDst : '0;

  genvar e, s, k, i, j;
  generate
    for (e = 0; e < NUM_SLOTS; e++) begin : g_shadow
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              shadowQ[e] <= '0;
        else if (!strobe.freeze) shadowQ[e] <= shadowD[e];
      end
    end

    for (s = 0; s < NUM_SLOTS; s++) begin : g_slot
      for (k = 0; k < SRCS_PER_SLOT; k++) begin : g_src
        for (e = 0; e < NUM_SLOTS; e++) begin : g_ent
          assign shHit[s][k*NUM_SLOTS+e] = specMatch(slotSpec[s][k+1], shadowQ[e]);
        end
      end
    end

    for (i = 0; i < SPECS_PER_SLOT; i++) begin : g_lspec
      for (j = 0; j < SPECS_PER_SLOT; j++) begin : g_rspec
        assign cmpBits[i*SPECS_PER_SLOT+j] = specMatch(slotSpec[0][i], slotSpec[1][j]);
      end
    end
  endgenerate

  assign leftShadowHit  = |shHit[0];
  assign rightShadowHit = |shHit[1];
  assign pairConflict   = |cmpBits;

  // R9: a frozen cycle keeps both shadow entries
  assert_shadow_frozen_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.freeze |=> ($stable(shadowQ[0]) && $stable(shadowQ[1])));

  // R6: an issued left load becomes a shadow entry
  assert_shadow_capture_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.freeze && strobe.recLeft) |=> (shadowQ[0] == $past(leftDst)));

  // R6: without a new load, an entry lasts only one free cycle
  assert_shadow_expire_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.freeze && !strobe.recRight) |=> !shadowQ[1].vld);

endmodule

// File: rtl/pair_issue_ctrl.sv
module pair_issue_ctrl
  import dual_issue_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      stallIn,
  input  logic      leftValid,
  input  logic      leftIsLoad,
  input  logic      rightValid,
  input  logic      rightIsLoad,
  input  logic      leftShadowHit,
  input  logic      rightShadowHit,
  input  logic      pairConflict,
  output logic      grantLeft,
  output logic      grantRight,
  output logic      fetchHold,
  output dpStrobe_t strobe
);

  logic leftDone;
  logic leftDoneNext;
  logic leftPending;
  logic rightOrderOk;
  logic packetDone;

  assign leftPending  = leftValid && !leftDone;
  assign grantLeft    = !stallIn && leftPending && !leftShadowHit;
  assign rightOrderOk = leftPending ? (grantLeft && !pairConflict) : 1'b1;
  assign grantRight   = !stallIn && rightValid && !rightShadowHit && rightOrderOk;

  assign packetDone = !(leftPending && !grantLeft) && !(rightValid && !grantRight);
  assign fetchHold  = stallIn || !packetDone;

  always_comb begin
    if (stallIn)         leftDoneNext = leftDone;
    else if (packetDone) leftDoneNext = 1'b0;
    else                 leftDoneNext = leftDone || grantLeft;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) leftDone <= 1'b0;
    else       leftDone <= leftDoneNext;
  end

  assign strobe.freeze   = stallIn;
  assign strobe.recLeft  = grantLeft  && leftIsLoad;
  assign strobe.recRight = grantRight && rightIsLoad;

  // R3: right never overtakes a waiting left slot
  assert_right_order_R3: assert property (@(posedge clk) disable iff (!rstN)
    (grantRight && leftPending) |-> grantLeft);

  // R4: a pair issued together shares no register
  assert_pair_clean_R4: assert property (@(posedge clk) disable iff (!rstN)
    (grantLeft && grantRight) |-> !pairConflict);

  // R9: stall blocks both grants and holds fetch
  assert_stall_block_R9: assert property (@(posedge clk) disable iff (!rstN)
    stallIn |-> (!grantLeft && !grantRight && fetchHold));

  // R8: an issued left slot is not granted again
  assert_no_regrant_R8: assert property (@(posedge clk) disable iff (!rstN)
    leftDone |-> !grantLeft);

  // R8: a released packet leaves no issued mark
  assert_fresh_packet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !fetchHold |=> !leftDone);

  // R6: a shadow hit blocks the slot it hits
  assert_shadow_block_R6: assert property (@(posedge clk) disable iff (!rstN)
    (leftShadowHit |-> !grantLeft) and (rightShadowHit |-> !grantRight));

endmodule

// File: rtl/dual_issue_pairing.sv
module dual_issue_pairing
  import dual_issue_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              stallIn,
  input  logic              leftValid,
  input  logic              leftIsLoad,
  input  logic [SPEC_W-1:0] leftDst,
  input  logic [SPEC_W-1:0] leftSrcA,
  input  logic [SPEC_W-1:0] leftSrcB,
  input  logic              rightValid,
  input  logic              rightIsLoad,
  input  logic [SPEC_W-1:0] rightDst,
  input  logic [SPEC_W-1:0] rightSrcA,
  input  logic [SPEC_W-1:0] rightSrcB,
  output logic              grantLeft,
  output logic              grantRight,
  output logic              fetchHold
);

  dpStrobe_t strobe;
  logic leftShadowHit;
  logic rightShadowHit;
  logic pairConflict;

  pair_hazard_dp i_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .leftDst        (regSpec_t'(leftDst)),
    .leftSrcA       (regSpec_t'(leftSrcA)),
    .leftSrcB       (regSpec_t'(leftSrcB)),
    .rightDst       (regSpec_t'(rightDst)),
    .rightSrcA      (regSpec_t'(rightSrcA)),
    .rightSrcB      (regSpec_t'(rightSrcB)),
    .leftShadowHit  (leftShadowHit),
    .rightShadowHit (rightShadowHit),
    .pairConflict   (pairConflict)
  );

  pair_issue_ctrl i_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .stallIn        (stallIn),
    .leftValid      (leftValid),
    .leftIsLoad     (leftIsLoad),
    .rightValid     (rightValid),
    .rightIsLoad    (rightIsLoad),
    .leftShadowHit  (leftShadowHit),
    .rightShadowHit (rightShadowHit),
    .pairConflict   (pairConflict),
    .grantLeft      (grantLeft),
    .grantRight     (grantRight),
    .fetchHold      (fetchHold),
    .strobe         (strobe)
  );

endmodule

// File: tb/test_dual_issue_pairing.sv
module test_dual_issue_pairing;
  timeunit 1ns;
  timeprecision 1ps;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, stallIn;
  logic leftValid, leftIsLoad, rightValid, rightIsLoad;
  logic [6:0] leftDst, leftSrcA, leftSrcB, rightDst, rightSrcA, rightSrcB;
  logic grantLeft, grantRight, fetchHold;

  int checks = 0;
  int errors = 0;

  logic mDone;
  logic [6:0] mSh0, mSh1;
  logic eL, eR, eH;

  dual_issue_pairing i_dual_issue_pairing (
    .clk(clk), .rstN(rstN), .stallIn(stallIn),
    .leftValid(leftValid), .leftIsLoad(leftIsLoad),
    .leftDst(leftDst), .leftSrcA(leftSrcA), .leftSrcB(leftSrcB),
    .rightValid(rightValid), .rightIsLoad(rightIsLoad),
    .rightDst(rightDst), .rightSrcA(rightSrcA), .rightSrcB(rightSrcB),
    .grantLeft(grantLeft), .grantRight(grantRight), .fetchHold(fetchHold)
  );

  // R1: same register when both valid and file+index equal
  function automatic logic same(logic [6:0] a, logic [6:0] b);
    return a[6] && b[6] && (a[5:0] == b[5:0]);
  endfunction

  function automatic logic shHit(logic [6:0] a, logic [6:0] b);
    return same(a, mSh0) || same(a, mSh1) || same(b, mSh0) || same(b, mSh1);
  endfunction

  function automatic logic anyPair();
    logic [6:0] l [3];
    logic [6:0] r [3];
    logic hit;
    l[0] = leftDst;  l[1] = leftSrcA;  l[2] = leftSrcB;
    r[0] = rightDst; r[1] = rightSrcA; r[2] = rightSrcB;
    hit = 1'b0;
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        if (same(l[a], r[b])) hit = 1'b1;
    return hit;
  endfunction

  task automatic predict();
    logic pend, done;
    pend = leftValid && !mDone;
    eL = !stallIn && pend && !shHit(leftSrcA, leftSrcB);
    eR = !stallIn && rightValid && !shHit(rightSrcA, rightSrcB)
         && (pend ? (eL && !anyPair()) : 1'b1);
    done = !(pend && !eL) && !(rightValid && !eR);
    eH = stallIn || !done;
  endtask

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic cycle(string tL, string tR, string tH);
    #2;
    predict();
    chk(tL, grantLeft, eL);
    chk(tR, grantRight, eR);
    chk(tH, fetchHold, eH);
    @(posedge clk);
    if (!stallIn) begin
      mSh0 = (eL && leftIsLoad)  ? leftDst  : 7'd0;
      mSh1 = (eR && rightIsLoad) ? rightDst : 7'd0;
      mDone = eH ? (mDone || eL) : 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic setPkt(logic lv, logic ll, logic [6:0] ld, logic [6:0] la, logic [6:0] lb,
                        logic rv, logic rl, logic [6:0] rd, logic [6:0] ra, logic [6:0] rb);
    leftValid = lv; leftIsLoad = ll; leftDst = ld; leftSrcA = la; leftSrcB = lb;
    rightValid = rv; rightIsLoad = rl; rightDst = rd; rightSrcA = ra; rightSrcB = rb;
  endtask

  function automatic logic [6:0] rndSpec();
    return {($urandom % 4) != 0, 1'($urandom % 2), 5'($urandom % 4)};
  endfunction

  localparam logic [6:0] INT1 = 7'b1000001;
  localparam logic [6:0] INT2 = 7'b1000010;
  localparam logic [6:0] FP1  = 7'b1100001;
  localparam logic [6:0] FP3  = 7'b1100011;
  localparam logic [6:0] FP5  = 7'b1100101;
  localparam logic [6:0] FP6  = 7'b1100110;
  localparam logic [6:0] NONE = 7'b0000000;

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog R7 actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rstN = 1'b0; stallIn = 1'b0;
    mDone = 1'b0; mSh0 = '0; mSh1 = '0;
    setPkt(0, 0, NONE, NONE, NONE, 0, 0, NONE, NONE, NONE);
    repeat (2) @(negedge clk);
    #2;
    chk("R10 grantLeft in reset", grantLeft, 1'b0);
    chk("R10 grantRight in reset", grantRight, 1'b0);
    chk("R10 fetchHold empty packet", fetchHold, 1'b0);
    @(negedge clk);
    rstN = 1'b1;

    // R10: empty shadow after reset, independent pair issues together
    setPkt(1, 0, INT1, INT2, NONE, 1, 0, FP5, FP6, NONE);
    cycle("R10 grantLeft", "R10 grantRight", "R10 fetchHold");

    // R5: same-packet load use
    setPkt(1, 1, FP3, INT2, NONE, 1, 0, FP5, FP3, NONE);
    #2; chk("R5 left load issues", grantLeft, 1'b1);
    chk("R5 partner refused", grantRight, 1'b0);
    chk("R5 hold", fetchHold, 1'b1);
    #0;
    #(-0);
    cycle("R5 grantLeft", "R5 grantRight", "R5 fetchHold");
    #2; chk("R8 no regrant", grantLeft, 1'b0);
    chk("R6 shadow blocks retry", grantRight, 1'b0);
    cycle("R8 grantLeft", "R6 grantRight", "R6 fetchHold");
    #2; chk("R5 retry issues", grantRight, 1'b1);
    chk("R7 packet done", fetchHold, 1'b0);
    cycle("R8 grantLeft", "R5 grantRight", "R7 fetchHold");

    // R6: next-packet load use through the left slot
    setPkt(1, 1, INT2, INT1, NONE, 1, 0, FP5, FP6, NONE);
    cycle("R6 grantLeft", "R6 grantRight", "R6 fetchHold");
    setPkt(1, 0, FP6, INT2, NONE, 1, 0, FP5, FP1, NONE);
    #2; chk("R6 next packet blocked", grantLeft, 1'b0);
    chk("R3 right waits for left", grantRight, 1'b0);
    cycle("R6 grantLeft", "R3 grantRight", "R6 fetchHold");
    #2; chk("R6 shadow expired", grantLeft, 1'b1);
    cycle("R6 grantLeft", "R3 grantRight", "R7 fetchHold");

    // R4 and R1: conflict only within the same file
    setPkt(1, 0, INT1, NONE, NONE, 1, 0, FP5, INT1, NONE);
    #2; chk("R4 conflicting pair split", grantRight, 1'b0);
    cycle("R4 grantLeft", "R4 grantRight", "R4 fetchHold");
    cycle("R8 grantLeft", "R4 grantRight", "R7 fetchHold");
    setPkt(1, 0, INT1, NONE, NONE, 1, 0, FP5, FP1, NONE);
    #2; chk("R1 other file no conflict", grantRight, 1'b1);
    cycle("R1 grantLeft", "R1 grantRight", "R1 fetchHold");

    // R9: stall inside the shadow window keeps the shadow
    setPkt(0, 0, NONE, NONE, NONE, 1, 1, FP5, FP6, NONE);
    cycle("R3 grantLeft", "R3 grantRight", "R7 fetchHold");
    setPkt(1, 0, INT1, FP5, NONE, 1, 0, FP6, FP1, NONE);
    stallIn = 1'b1;
    #2; chk("R9 no left grant", grantLeft, 1'b0);
    chk("R9 no right grant", grantRight, 1'b0);
    chk("R9 hold", fetchHold, 1'b1);
    cycle("R9 grantLeft", "R9 grantRight", "R9 fetchHold");
    cycle("R9 grantLeft", "R9 grantRight", "R9 fetchHold");
    stallIn = 1'b0;
    #2; chk("R9 shadow kept", grantLeft, 1'b0);
    cycle("R9 grantLeft", "R9 grantRight", "R9 fetchHold");
    #2; chk("R6 released after stall", grantLeft, 1'b1);
    cycle("R6 grantLeft", "R3 grantRight", "R7 fetchHold");

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      if (!eH)
        setPkt(($urandom % 8) != 0, ($urandom % 3) == 0, rndSpec(), rndSpec(), rndSpec(),
               ($urandom % 8) != 0, ($urandom % 3) == 0, rndSpec(), rndSpec(), rndSpec());
      stallIn = ($urandom % 8) == 0;
      cycle("R2 grantLeft", "R3 grantRight", "R7 fetchHold");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule